// File: doc/BRIEF.md
# Over-Current Fault Latch with Self-Clearing Option

This block guards a pulse-width output stage against over-current. Every clock it compares the magnitude of the difference between two signed measurement words with a programmable limit. When that condition persists longer than a programmable qualification time, it latches an active-low fault flag. While the flag is latched, the active-low pulse output is forced to its inactive (high) level, whatever the pulse request is.

There is no dedicated clear input. The fault is released by watching the level of the pulse-output line: the line must read low for a programmable number of consecutive clocks. After a release, if the over-current condition is still there, the fault is not re-qualified. It latches again at the first clock that sees the synchronisation input change level. If the condition goes away first, the block returns to idle.

With the self-clear mode enabled, the fault flag is treated as wired onto the pulse-output line. The latched fault pulls the sensed line low and so times out its own release. All inputs are plain levels sampled on every clock, and there is no back-pressure. The measurements and limits are read continuously rather than transferred as a stream, so no valid/ready handshake applies.

Top module: `ocp_fault_latch`

## Requirements
- R1: After reset, `fault_n` is 1, `pwm_out_n` equals `pwm_req_n`, and both the qualification count and the release count are zero. Over-current samples seen before a reset do not count towards qualification afterwards.
- R2: Over-current means |`meas_p` − `meas_m`| > `oc_limit`. Both measurements are two's-complement numbers of MEAS_W bits, and the limit is unsigned with MEAS_W+1 bits. A magnitude equal to the limit is not over-current.
- R3: With `qual_cycles` = Q, `fault_n` goes to 0 just after the (Q+1)th consecutive rising edge that samples over-current, and not before.
- R4: A single edge that samples no over-current restarts qualification from zero.
- R5: While `fault_n` is 0, `pwm_out_n` is 1. While `fault_n` is 1, `pwm_out_n` equals `pwm_req_n`.
- R6: With `release_cycles` = R, a latched fault clears (`fault_n` = 1) just after the (R+1)th consecutive rising edge that samples the effective line low.
- R7: A high effective line sampled before the release count completes keeps the fault latched and restarts the release count from zero.
- R8: After a release, if over-current is still sampled, `fault_n` returns to 0 just after the first rising edge at which `sync_in` differs from its value at the previous edge, in either direction. If an edge samples no over-current first, the block goes idle and a later `sync_in` change does not set the fault.
- R9: When `auto_clear_en` = 1, the effective line is `line_sense` AND `fault_n`, so a latched fault releases itself after R+1 edges even though `line_sense` stays high. When `auto_clear_en` = 0, the effective line is `line_sense`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Carrier synchronisation level; either change re-arms a still-present fault |
| meas_p | input | MEAS_W | Signed positive measurement |
| meas_m | input | MEAS_W | Signed negative measurement |
| oc_limit | input | MEAS_W+1 | Unsigned over-current magnitude limit |
| qual_cycles | input | CNT_W | Qualification time Q in clocks |
| release_cycles | input | CNT_W | Release time R in clocks |
| auto_clear_en | input | 1 | Fault flag treated as wired onto the pulse-output line |
| line_sense | input | 1 | Observed level of the pulse-output line |
| pwm_req_n | input | 1 | Active-low pulse request from the modulator |
| pwm_out_n | output | 1 | Active-low pulse output, forced high during a fault |
| fault_n | output | 1 | Active-low latched over-current flag |

## Verification
The table of measurement pairs targets the magnitude boundary: equal-to-limit cases and the most negative difference. A design that compared with >= or dropped the extra sign bit would latch on these, or miss them. Directed tests place the fault exactly one edge after the Q-th and R-th sample, insert a one-edge gap in the over-current and a one-edge high on the line, and hold `sync_in` still after a release. A design that accumulated instead of restarting, was off by one, or re-latched without a SYNC change would flip `fault_n` on the wrong edge. Self-clear mode is checked with `line_sense` tied high: a design that ignored the internal wired-AND would never release.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUALIFY = 2'd1,
    ST_LATCHED = 2'd2,
    ST_REARM   = 2'd3
  } ocp_state_e;

endpackage

// File: rtl/ocp_mag_cmp.sv
module ocp_mag_cmp #(
  parameter int MEAS_W = 8
) (
  input  logic signed [MEAS_W-1:0] a_in,
  input  logic signed [MEAS_W-1:0] b_in,
  input  logic        [MEAS_W:0]   limit,
  output logic                     over
);
  localparam int DW = MEAS_W + 1;
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] diff;
  logic [DW-1:0] mag;

  // sign-extend by one bit so the full difference range fits
  assign diff = {a_in[MEAS_W-1], a_in} - {b_in[MEAS_W-1], b_in};
  assign mag  = diff[DW-1] ? (~diff + ONE) : diff;
  assign over = (mag > limit);
endmodule

// File: rtl/ocp_run_counter.sv
module ocp_run_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cond,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  // hit on the (limit+1)th consecutive sample with cond true
  assign hit = en && cond && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (en && cond && !hit)    cnt <= cnt + 1'b1;
    else                            cnt <= '0;
  end
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch
  import ocp_pkg::*;
#(
  parameter int MEAS_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic signed [MEAS_W-1:0] meas_p,
  input  logic signed [MEAS_W-1:0] meas_m,
  input  logic        [MEAS_W:0]   oc_limit,
  input  logic        [CNT_W-1:0]  qual_cycles,
  input  logic        [CNT_W-1:0]  release_cycles,
  input  logic                     auto_clear_en,
  input  logic                     line_sense,
  input  logic                     pwm_req_n,
  output logic                     pwm_out_n,
  output logic                     fault_n
);
  ocp_state_e state, state_nx;
  logic over, sync_q, sync_edge, line_eff;
  logic qual_hit, rel_hit;

  ocp_mag_cmp #(.MEAS_W(MEAS_W)) u_cmp (
    .a_in(meas_p), .b_in(meas_m), .limit(oc_limit), .over(over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end
  assign sync_edge = sync_in ^ sync_q;

  assign fault_n   = (state != ST_LATCHED);
  assign line_eff  = line_sense & (fault_n | ~auto_clear_en);
  assign pwm_out_n = pwm_req_n | ~fault_n;

  ocp_run_counter #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .en((state == ST_IDLE) || (state == ST_QUALIFY)),
    .cond(over), .limit(qual_cycles), .hit(qual_hit)
  );

  ocp_run_counter #(.CNT_W(CNT_W)) u_rel (
    .clk(clk), .rst_n(rst_n),
    .en(state == ST_LATCHED),
    .cond(~line_eff), .limit(release_cycles), .hit(rel_hit)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (qual_hit) state_nx = ST_LATCHED;
                  else if (over) state_nx = ST_QUALIFY;
      ST_QUALIFY: if (qual_hit) state_nx = ST_LATCHED;
                  else if (!over) state_nx = ST_IDLE;
      ST_LATCHED: if (rel_hit) state_nx = ST_REARM;
      ST_REARM:   if (!over) state_nx = ST_IDLE;
                  else if (sync_edge) state_nx = ST_LATCHED;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R3/R8: the fault never sets without over-current at that edge
  assert_fault_needs_overcurrent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(over));

  // R6: a release is always preceded by a low effective line
  assert_release_needs_low_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(!line_eff));

  // R7: a high line sample never releases the fault
  assert_high_line_holds_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && line_eff) |=> !fault_n);

  // R8: no re-latch without a SYNC level change
  assert_rearm_waits_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REARM && !sync_edge) |=> fault_n);
endmodule

// File: tb/test_ocp_fault_latch.sv
module test_ocp_fault_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic signed [7:0] meas_p = '0, meas_m = '0;
  logic [8:0] oc_limit = 9'd10;
  logic [15:0] qual_cycles = '0, release_cycles = '0;
  logic auto_clear_en = 1'b0, line_sense = 1'b1, pwm_req_n = 1'b1;
  logic pwm_out_n, fault_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocp_fault_latch #(.MEAS_W(8), .CNT_W(16)) i_ocp_fault_latch (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .meas_p(meas_p), .meas_m(meas_m),
    .oc_limit(oc_limit), .qual_cycles(qual_cycles), .release_cycles(release_cycles),
    .auto_clear_en(auto_clear_en), .line_sense(line_sense), .pwm_req_n(pwm_req_n),
    .pwm_out_n(pwm_out_n), .fault_n(fault_n)
  );

  typedef struct packed {
    logic signed [7:0] p;
    logic signed [7:0] m;
    logic [8:0]        lim;
    logic              exp_over;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'sd10,   8'sd5,   9'd4,   1'b1},
    '{8'sd10,   8'sd5,   9'd5,   1'b0},
    '{-8'sd100, 8'sd27,  9'd126, 1'b1},
    '{-8'sd128, 8'sd127, 9'd254, 1'b1},
    '{-8'sd128, 8'sd127, 9'd255, 1'b0},
    '{8'sd0,    8'sd0,   9'd0,   1'b0},
    '{8'sd3,   -8'sd3,   9'd5,   1'b1},
    '{-8'sd7,  -8'sd7,   9'd0,   1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic set_over(input bit on);
    meas_p = on ? 8'sd50 : 8'sd0;
    meas_m = 8'sd0;
    oc_limit = 9'd10;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(1);
    // R1: reset state
    pwm_req_n = 1'b0;
    do_reset();
    check("R1 fault_n after reset", fault_n, 1'b1);
    check("R1 pwm follows request", pwm_out_n, 1'b0);

    // R2: vector table, Q=0 so one over-current edge latches
    for (int i = 0; i < 8; i++) begin
      do_reset();
      meas_p = VECS[i].p; meas_m = VECS[i].m; oc_limit = VECS[i].lim;
      step(1);
      check($sformatf("R2 vector %0d fault_n", i), fault_n, ~VECS[i].exp_over);
    end

    // R3 / R5: qualification with Q=3
    do_reset();
    qual_cycles = 16'd3;
    set_over(1);
    step(3);
    check("R3 not latched after Q edges", fault_n, 1'b1);
    check("R5 pwm passes before fault", pwm_out_n, 1'b0);
    step(1);
    check("R3 latched after Q+1 edges", fault_n, 1'b0);
    check("R5 pwm forced high in fault", pwm_out_n, 1'b1);

    // R4: one gap restarts qualification
    do_reset();
    set_over(1); step(3);
    set_over(0); step(1);
    set_over(1); step(3);
    check("R4 gap restarts count", fault_n, 1'b1);
    step(1);
    check("R4 latched after full run", fault_n, 1'b0);

    // R1: samples before reset do not count afterwards
    do_reset();
    set_over(1); step(2);
    do_reset();
    step(2);
    check("R1 counter cleared by reset", fault_n, 1'b1);

    // R6 / R7: manual release with R=2
    do_reset();
    qual_cycles = 16'd0; release_cycles = 16'd2;
    set_over(1); step(1);
    check("R6 latched for release test", fault_n, 1'b0);
    set_over(0);
    line_sense = 1'b0; step(2);
    line_sense = 1'b1; step(1);
    check("R7 high line keeps fault", fault_n, 1'b0);
    line_sense = 1'b0; step(2);
    check("R7 count restarted", fault_n, 1'b0);
    step(1);
    check("R6 released after R+1 low edges", fault_n, 1'b1);
    line_sense = 1'b1;
    step(1);
    check("R5 pwm follows request after release", pwm_out_n, 1'b0);

    // R8: re-latch on SYNC change while over-current stays
    do_reset();
    set_over(1); step(1);
    line_sense = 1'b0; step(3);
    check("R8 released with over-current present", fault_n, 1'b1);
    line_sense = 1'b1; step(3);
    check("R8 no re-latch without SYNC change", fault_n, 1'b1);
    sync_in = ~sync_in; step(1);
    check("R8 re-latch on SYNC change", fault_n, 1'b0);
    line_sense = 1'b0; step(3);
    line_sense = 1'b1;
    set_over(0); step(1);
    sync_in = ~sync_in; step(1);
    check("R8 idle after condition drops", fault_n, 1'b1);

    // R9: self-clear with line_sense held high, R=3
    do_reset();
    auto_clear_en = 1'b1; release_cycles = 16'd3; line_sense = 1'b1;
    set_over(1); step(1);
    check("R9 latched in self-clear mode", fault_n, 1'b0);
    set_over(0); step(3);
    check("R9 still latched after R edges", fault_n, 1'b0);
    step(1);
    check("R9 self-released after R+1 edges", fault_n, 1'b1);
    step(2);
    check("R9 stays released", fault_n, 1'b1);

    // R9: with self-clear off, a high line never releases
    do_reset();
    auto_clear_en = 1'b0;
    set_over(1); step(1);
    set_over(0); step(8);
    check("R9 no self-release when disabled", fault_n, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule